// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block sits beside the timekeeping counters of a real-time clock and decides, once per second, whether either of two programmable alarms has come due. It compares the current BCD time fields against the alarm bytes and emits a single-cycle strobe per alarm. Flag storage, the register bus and the counters themselves live elsewhere: the block only sees the current time, the alarm bytes and a tick that marks the cycle after the time fields have settled on a new second.

Each alarm byte carries an ignore bit in bit 7. When it is set, that field drops out of the comparison, which yields a ladder of rates from "every second" up to "this exact day and time". The top byte of each alarm also carries a selector in bit 6 that chooses between the weekday and the day of the month. The first alarm has seconds, minutes, hours and day fields. The second alarm has no seconds field and is therefore only ever evaluated at second 00, so with every field ignored it fires once a minute.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `rst_n` is low both strobes are 0, whatever the other inputs are.
- R2: A strobe is high only in the cycle after a cycle in which `tick` was 1; with `tick` at 0 neither strobe rises.
- R3: In the seconds, minutes and hours alarm bytes, bit 7 = 1 removes that field from the comparison; with bit 7 = 0, bits 6:0 must equal the current 7-bit BCD field.
- R4: Alarm 1 with all four ignore bits set (day, hours, minutes, seconds = 1111) strobes on every tick.
- R5: Alarm 1 codes 1110, 1100, 1000 and 0000 (day, hours, minutes, seconds) fire on a seconds match, on minutes and seconds, on hours, minutes and seconds, and on the full time plus the day field respectively.
- R6: In a day byte with bit 7 = 0, bit 6 = 0 compares bits 5:0 with the day of month and bit 6 = 1 compares bits 3:0 with the weekday; with bit 7 = 1 the day field is not compared at all.
- R7: Alarm 2 strobes only on ticks where the current seconds value is 00; with all three ignore bits set (111) it strobes on every such tick.
- R8: Alarm 2 codes 110, 100 and 000 (day, hours, minutes) fire on a minutes match, on hours and minutes, and on day, hours and minutes respectively, always at second 00.
- R9: Ignore-bit combinations outside the rate ladder (for example day and minutes compared, hours and seconds ignored) compare exactly the fields whose bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse after the time fields update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_wday | input | 4 | Current weekday |
| a1_sec | input | 8 | Alarm 1 seconds byte, bit 7 ignore |
| a1_min | input | 8 | Alarm 1 minutes byte, bit 7 ignore |
| a1_hour | input | 8 | Alarm 1 hours byte, bit 7 ignore |
| a1_day | input | 8 | Alarm 1 day byte, bit 7 ignore, bit 6 weekday select |
| a2_min | input | 8 | Alarm 2 minutes byte, bit 7 ignore |
| a2_hour | input | 8 | Alarm 2 hours byte, bit 7 ignore |
| a2_day | input | 8 | Alarm 2 day byte, bit 7 ignore, bit 6 weekday select |
| a1_hit | output | 1 | Alarm 1 match strobe |
| a2_hit | output | 1 | Alarm 2 match strobe |

## Verification
The bench builds the block with its default widths: 7-bit time fields, a 6-bit day of month and a 4-bit weekday, which are the widths the bit positions in the requirements refer to. At these widths both the full BCD ranges and small value pools can be drawn, so a random phase that picks times and alarm fields from the same few values hits true matches, near misses and every ignore-bit combination, including those off the rate ladder. Directed steps pin the second-00 gate of alarm 2 and the weekday/day-of-month selector with its ignore bit.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FIELD_W = 7,
  parameter int MDAY_W  = 6,
  parameter int WDAY_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [MDAY_W-1:0]  cur_mday,
  input  logic [WDAY_W-1:0]  cur_wday,
  input  logic [FIELD_W:0]   a1_sec,
  input  logic [FIELD_W:0]   a1_min,
  input  logic [FIELD_W:0]   a1_hour,
  input  logic [FIELD_W:0]   a1_day,
  input  logic [FIELD_W:0]   a2_min,
  input  logic [FIELD_W:0]   a2_hour,
  input  logic [FIELD_W:0]   a2_day,
  output logic               a1_hit,
  output logic               a2_hit
);

  localparam int IGN = FIELD_W;
  localparam int SEL = FIELD_W - 1;

  function automatic logic field_ok(input logic [FIELD_W:0] b,
                                    input logic [FIELD_W-1:0] cur);
    return b[IGN] | (b[FIELD_W-1:0] == cur);
  endfunction

  function automatic logic day_ok(input logic [FIELD_W:0] b,
                                  input logic [MDAY_W-1:0] md,
                                  input logic [WDAY_W-1:0] wd);
    if (b[IGN]) return 1'b1;
    if (b[SEL]) return b[WDAY_W-1:0] == wd;
    return b[MDAY_W-1:0] == md;
  endfunction

  logic sec_zero, a1_fire, a2_fire;

  assign sec_zero = (cur_sec == '0);

  assign a1_fire = field_ok(a1_sec, cur_sec) & field_ok(a1_min, cur_min) &
                   field_ok(a1_hour, cur_hour) & day_ok(a1_day, cur_mday, cur_wday);

  assign a2_fire = sec_zero & field_ok(a2_min, cur_min) &
                   field_ok(a2_hour, cur_hour) & day_ok(a2_day, cur_mday, cur_wday);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_hit <= 1'b0;
      a2_hit <= 1'b0;
    end else begin
      a1_hit <= tick & a1_fire;
      a2_hit <= tick & a2_fire;
    end
  end

  AST_NO_TICK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !a1_hit && !a2_hit); // R2

  AST_A2_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cur_sec != '0 |=> !a2_hit); // R7

  AST_A1_ALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    tick && a1_sec[IGN] && a1_min[IGN] && a1_hour[IGN] && a1_day[IGN] |=> a1_hit); // R4

  AST_A2_EVERY_MINUTE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cur_sec == '0 && a2_min[IGN] && a2_hour[IGN] && a2_day[IGN] |=> a2_hit); // R7

  AST_A1_SEC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !a1_sec[IGN] && a1_sec[FIELD_W-1:0] != cur_sec |=> !a1_hit); // R3

  AST_WDAY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !a1_day[IGN] && a1_day[SEL] && a1_day[WDAY_W-1:0] != cur_wday |=> !a1_hit); // R6

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!a1_hit && !a2_hit); // R1
  end

endmodule

// File: tb/rtc_alarm_match_tb.sv
`timescale 1ns/1ps
module rtc_alarm_match_tb;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [6:0] cs = 0, cmin = 0, ch = 0;
  logic [5:0] cmd = 1;
  logic [3:0] cwd = 1;
  logic [7:0] a1s = 0, a1m = 0, a1h = 0, a1d = 0, a2m = 0, a2h = 0, a2d = 0;
  logic a1_hit, a2_hit;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cs), .cur_min(cmin), .cur_hour(ch), .cur_mday(cmd), .cur_wday(cwd),
    .a1_sec(a1s), .a1_min(a1m), .a1_hour(a1h), .a1_day(a1d),
    .a2_min(a2m), .a2_hour(a2h), .a2_day(a2d),
    .a1_hit(a1_hit), .a2_hit(a2_hit));

  function automatic bit day_match(logic [7:0] d);
    int want, have;
    if (d[6]) begin want = d[3:0]; have = cwd; end
    else begin want = d[5:0]; have = cmd; end
    return want == have;
  endfunction

  function automatic bit ref1();
    logic [7:0] b[3];
    int now[3];
    bit ok = 1;
    b[0] = a1s; b[1] = a1m; b[2] = a1h;
    now[0] = cs; now[1] = cmin; now[2] = ch;
    for (int i = 0; i < 3; i++)
      if (!b[i][7] && int'(b[i][6:0]) != now[i]) ok = 0;
    if (!a1d[7] && !day_match(a1d)) ok = 0;
    return ok;
  endfunction

  function automatic bit ref2();
    bit ok = (cs == 0);
    if (!a2m[7] && a2m[6:0] != cmin) ok = 0;
    if (!a2h[7] && a2h[6:0] != ch) ok = 0;
    if (!a2d[7] && !day_match(a2d)) ok = 0;
    return ok;
  endfunction

  task automatic step(input string tag);
    bit e1, e2;
    e1 = rst_n && tick && ref1();
    e2 = rst_n && tick && ref2();
    @(posedge clk);
    #1;
    total++;
    if (a1_hit !== e1 || a2_hit !== e2) begin
      bad++;
      $display("FAIL %s: a1_hit=%0b a2_hit=%0b expected %0b %0b", tag, a1_hit, a2_hit, e1, e2);
    end
  endtask

  task automatic expect_bits(input string tag, input bit x1, input bit x2);
    total++;
    if (a1_hit !== x1 || a2_hit !== x2) begin
      bad++;
      $display("FAIL %s: a1_hit=%0b a2_hit=%0b expected %0b %0b", tag, a1_hit, a2_hit, x1, x2);
    end
  endtask

  task automatic set_time(input logic [6:0] s, m, h, input logic [5:0] md, input logic [3:0] wd);
    cs = s; cmin = m; ch = h; cmd = md; cwd = wd;
  endtask

  function automatic logic [7:0] pick7();
    logic [6:0] pool[4] = '{7'h00, 7'h25, 7'h59, 7'h12};
    return {$urandom_range(1, 0) == 1, pool[$urandom_range(3, 0)]};
  endfunction

  initial begin
    // R1: reset holds strobes low even with tick and everything ignored
    a1s = 8'h80; a1m = 8'h80; a1h = 8'h80; a1d = 8'h80;
    a2m = 8'h80; a2h = 8'h80; a2d = 8'h80;
    tick = 1;
    step("R1");
    step("R1");
    expect_bits("R1", 0, 0);
    rst_n = 1; tick = 0;
    step("R2");
    expect_bits("R2", 0, 0);

    // R4: all ignored fires every tick; R7 alarm 2 every minute at 00
    tick = 1;
    set_time(7'h00, 7'h10, 7'h08, 6'h15, 4'h3); step("R7");
    expect_bits("R7", 1, 1);
    set_time(7'h01, 7'h10, 7'h08, 6'h15, 4'h3); step("R4");
    expect_bits("R4", 1, 0);
    tick = 0; step("R2");
    expect_bits("R2", 0, 0);
    tick = 1;

    // R3 / R5: 1110 seconds match
    a1s = 8'h25; set_time(7'h25, 7'h33, 7'h11, 6'h07, 4'h2); step("R5");
    expect_bits("R5", 1, 0);
    set_time(7'h26, 7'h33, 7'h11, 6'h07, 4'h2); step("R3");
    expect_bits("R3", 0, 0);
    // 1100
    a1m = 8'h33; set_time(7'h25, 7'h33, 7'h11, 6'h07, 4'h2); step("R5");
    set_time(7'h25, 7'h34, 7'h11, 6'h07, 4'h2); step("R5");
    // 1000
    a1h = 8'h11; set_time(7'h25, 7'h33, 7'h11, 6'h07, 4'h2); step("R5");
    set_time(7'h25, 7'h33, 7'h12, 6'h07, 4'h2); step("R5");
    // 0000 with day of month (bit6=0)
    a1d = 8'h07; set_time(7'h25, 7'h33, 7'h11, 6'h07, 4'h2); step("R5");
    expect_bits("R5", 1, 0);
    set_time(7'h25, 7'h33, 7'h11, 6'h08, 4'h7); step("R6");
    expect_bits("R6", 0, 0);
    // weekday select (bit6=1), bits 3:0 compared with weekday
    a1d = 8'h42; set_time(7'h25, 7'h33, 7'h11, 6'h31, 4'h2); step("R6");
    expect_bits("R6", 1, 0);
    set_time(7'h25, 7'h33, 7'h11, 6'h02, 4'h5); step("R6");
    expect_bits("R6", 0, 0);
    // ignore bit overrides selector
    a1d = 8'hC9; set_time(7'h25, 7'h33, 7'h11, 6'h02, 4'h5); step("R6");
    expect_bits("R6", 1, 0);

    // R9: day and minutes compared, hours and seconds ignored
    a1s = 8'hA5; a1m = 8'h40; a1h = 8'h91; a1d = 8'h12;
    set_time(7'h03, 7'h40, 7'h22, 6'h12, 4'h1); step("R9");
    expect_bits("R9", 1, 0);
    set_time(7'h03, 7'h41, 7'h22, 6'h12, 4'h1); step("R9");
    expect_bits("R9", 0, 0);

    // R8: alarm 2 ladder
    a1s = 8'h80; a1m = 8'h80; a1h = 8'h80; a1d = 8'h80;
    a2m = 8'h45;
    set_time(7'h00, 7'h45, 7'h09, 6'h01, 4'h1); step("R8");
    expect_bits("R8", 1, 1);
    set_time(7'h30, 7'h45, 7'h09, 6'h01, 4'h1); step("R7");
    expect_bits("R7", 1, 0);
    a2h = 8'h09;
    set_time(7'h00, 7'h45, 7'h10, 6'h01, 4'h1); step("R8");
    expect_bits("R8", 1, 0);
    a2d = 8'h44;
    set_time(7'h00, 7'h45, 7'h09, 6'h01, 4'h4); step("R8");
    expect_bits("R8", 1, 1);
    a2d = 8'h01;
    set_time(7'h00, 7'h45, 7'h09, 6'h02, 4'h1); step("R8");
    expect_bits("R8", 1, 0);

    // random phase compared every clock against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d;
      tick = ($urandom_range(3, 0) != 0);
      a1s = pick7(); a1m = pick7(); a1h = pick7();
      a2m = pick7(); a2h = pick7();
      d = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 6'($urandom_range(2, 1))};
      a1d = d;
      d = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 6'($urandom_range(2, 1))};
      a2d = d;
      set_time(pick7()[6:0], pick7()[6:0], pick7()[6:0],
               6'($urandom_range(2, 1)), 4'($urandom_range(2, 1)));
      step("R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule